// File: doc/BRIEF.md
# Lookup Table Indirect Access Port

This block is the register front end of a switch address lookup table. A 32-bit host bus never reaches the table memory directly. The host first puts a 96-bit entry into three 32-bit staging registers. It then writes a table command register. That register carries an entry index in its low bits and a store flag in bit 31. With the flag set, the staged entry is copied into the table. With the flag clear, the indexed entry is fetched back into the staging registers, where the host can read it.

Around this path sit several other registers:
- a read-only revision register;
- a global control register holding an enable bit, a self-clearing table wipe bit, a one-shot ageing request bit and nine policy flags;
- a clock prescale value;
- a register of four 6-bit port sets that apply when the VLAN is unknown;
- one control word per port.

The wipe runs a sequencer that zeroes one entry per clock. Learning, forwarding and ageing themselves happen elsewhere; this block only hands the enable, the flags and the ageing pulse to that logic.

Top module: `ltp_indirect_port`

## Requirements
- R1: After reset, the control register reads 0, `ctrl_enable`, `ctrl_flags`, `age_req` and `clr_busy` are 0, and the table command register reads 0.
- R2: Offset 0x00 reads `{16'h0, REV_MAJOR, REV_MINOR}`, with the major revision in bits 15:8 and the minor revision in bits 7:0. Writes to it have no effect.
- R3: At offset 0x08, bit 31 is the enable and drives `ctrl_enable`. Bits 8:0 are policy flags: they read back and drive `ctrl_flags`. Bits 28:9 are ignored and read 0.
- R4: A write to offset 0x08 with bit 29 set raises `age_req` for exactly the one cycle after the write completes. Bit 29 always reads 0.
- R5: A write to offset 0x08 with bit 30 set holds `clr_busy` high for exactly DEPTH cycles, starting the cycle after the write. During that time, bit 30 of offset 0x08 reads 1. Afterwards, every entry reads back as all zeros.
- R6: A write to the table command register (offset 0x20) with bit 31 set stores the staging words into the entry given by bits IDX_W-1:0. The staging words are at 0x34 (entry bits 95:64), 0x38 (bits 63:32) and 0x3C (bits 31:0).
- R7: A table command write with bit 31 clear loads the indexed entry into the three staging words, in the same word order.
- R8: Every table command write keeps `bus_rdy` low in its first cycle and completes in its second cycle, provided no wipe is running.
- R9: An index of DEPTH or more is ignored on a store, with no entry changed. On a fetch, such an index loads zeros into the staging words.
- R10: A table command write issued during a wipe keeps `bus_rdy` low until the wipe ends, then takes effect. Its result is not overwritten by the wipe.
- R11: The other registers keep only their defined bits:
  - prescale (0x10) keeps bits PRESCALE_W-1:0;
  - the unknown-VLAN register (0x18) keeps bits 29:24, 21:16, 13:8 and 5:0;
  - each port word at 0x40 + 4·p, for p below NUM_PORTS, keeps bits 31:16 and 5:0.
  Unmapped or misaligned offsets read 0 and ignore writes.
- R12: The table command register reads back the last index in its low bits, with bit 31 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until `bus_rdy` |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| bus_rdy | output | 1 | The access completes at the clock edge where this is high |
| ctrl_enable | output | 1 | Global enable bit |
| ctrl_flags | output | 9 | Policy flag bits |
| age_req | output | 1 | One-cycle ageing request pulse |
| clr_busy | output | 1 | Table wipe in progress |

## Verification
Register reads and writes outside the table command register finish at the first clock edge, with read data available before that edge. The `age_req` pulse and the start of `clr_busy` therefore fall in the first cycle after the write edge, and the bench samples them on the next falling edge. A table command write stalls for exactly one cycle, or for DEPTH+1 cycles when it is issued at the start of a wipe. The bench counts the low-`bus_rdy` cycles of each such transfer and compares that count with these figures. It reads the staging words only after the fetch has completed, and it measures the length of the wipe by counting falling edges at which `clr_busy` is high.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    localparam logic [7:0] OFS_ID    = 8'h00;
    localparam logic [7:0] OFS_CTRL  = 8'h08;
    localparam logic [7:0] OFS_PRESC = 8'h10;
    localparam logic [7:0] OFS_UNKV  = 8'h18;
    localparam logic [7:0] OFS_TCTL  = 8'h20;
    localparam logic [7:0] OFS_DW0   = 8'h34;
    localparam logic [7:0] OFS_PORT0 = 8'h40;

    localparam logic [31:0] UNKV_KEEP = 32'h3F3F_3F3F;
    localparam logic [31:0] PORT_KEEP = 32'hFFFF_003F;

    localparam int unsigned BIT_ENABLE = 31;
    localparam int unsigned BIT_WIPE   = 30;
    localparam int unsigned BIT_AGE    = 29;
    localparam int unsigned BIT_STORE  = 31;
    localparam int unsigned FLAG_W     = 9;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_ID,
        RS_CTRL,
        RS_PRESC,
        RS_UNKV,
        RS_TCTL,
        RS_DW,
        RS_PORT
    } reg_sel_e;

endpackage

// File: rtl/ltp_regdec.sv
module ltp_regdec
    import ltp_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [7:0]    addr,
    output reg_sel_e      sel,
    output logic [1:0]    dw_idx,
    output logic [PW-1:0] port_idx
);

    logic [7:0] port_off;
    logic [5:0] port_slot;

    always_comb begin
        port_off  = addr - OFS_PORT0;
        port_slot = port_off[7:2];
        sel       = RS_NONE;
        dw_idx    = 2'd0;
        port_idx  = PW'(port_slot);
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_ID) begin
                sel = RS_ID;
            end else if (addr == OFS_CTRL) begin
                sel = RS_CTRL;
            end else if (addr == OFS_PRESC) begin
                sel = RS_PRESC;
            end else if (addr == OFS_UNKV) begin
                sel = RS_UNKV;
            end else if (addr == OFS_TCTL) begin
                sel = RS_TCTL;
            end else if (addr == OFS_DW0) begin
                sel    = RS_DW;
                dw_idx = 2'd0;
            end else if (addr == OFS_DW0 + 8'd4) begin
                sel    = RS_DW;
                dw_idx = 2'd1;
            end else if (addr == OFS_DW0 + 8'd8) begin
                sel    = RS_DW;
                dw_idx = 2'd2;
            end else if (addr >= OFS_PORT0 && 32'(port_slot) < NUM_PORTS) begin
                sel = RS_PORT;
            end
        end
    end

endmodule

// File: rtl/ltp_table_ram.sv
module ltp_table_ram #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 96,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/ltp_wipe_seq.sv
module ltp_wipe_seq #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] idx
);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
    } wipe_st_t;

    wipe_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == AW'(DEPTH - 1)) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign idx  = st_q.idx;

endmodule

// File: rtl/ltp_indirect_port.sv
module ltp_indirect_port
    import ltp_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned NUM_PORTS  = 3,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned PRESCALE_W = 20,
    parameter logic [7:0]  REV_MAJOR  = 8'h01,
    parameter logic [7:0]  REV_MINOR  = 8'h03
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rdy,
    output logic        ctrl_enable,
    output logic [8:0]  ctrl_flags,
    output logic        age_req,
    output logic        clr_busy
);

    localparam int unsigned AW      = $clog2(DEPTH);
    localparam int unsigned ENTRY_W = 96;
    localparam int unsigned PW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IDX_W:0] DEPTH_LIM = (IDX_W + 1)'(DEPTH);

    typedef struct packed {
        logic                          enable;
        logic [FLAG_W-1:0]             flags;
        logic                          age;
        logic [PRESCALE_W-1:0]         presc;
        logic [31:0]                   unkv;
        logic [IDX_W-1:0]              tidx;
        logic                          tstore;
        logic                          phase;
        logic [2:0][31:0]              dw;
        logic [NUM_PORTS-1:0][31:0]    port;
    } port_st_t;

    port_st_t st_d, st_q;

    reg_sel_e            sel;
    logic [1:0]          dw_idx;
    logic [PW-1:0]       port_idx;
    logic                wipe_busy;
    logic [AW-1:0]       wipe_idx;
    logic                wipe_start;
    logic                ram_we;
    logic [AW-1:0]       ram_waddr;
    logic [ENTRY_W-1:0]  ram_wdata;
    logic [AW-1:0]       ram_raddr;
    logic [ENTRY_W-1:0]  ram_rdata;
    logic                tctl_wr;
    logic                tctl_issue;
    logic                tctl_finish;
    logic                wr_done;
    logic [IDX_W-1:0]    req_idx;
    logic                req_in_range;
    logic                held_in_range;
    logic [31:0]         rd_mux;

    ltp_regdec #(.NUM_PORTS(NUM_PORTS)) i_regdec (
        .addr     (bus_addr),
        .sel      (sel),
        .dw_idx   (dw_idx),
        .port_idx (port_idx)
    );

    ltp_wipe_seq #(.DEPTH(DEPTH)) i_wipe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wipe_start),
        .busy  (wipe_busy),
        .idx   (wipe_idx)
    );

    ltp_table_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // handshake and table command sequencing
    always_comb begin
        req_idx       = bus_wdata[IDX_W-1:0];
        req_in_range  = {1'b0, req_idx} < DEPTH_LIM;
        held_in_range = {1'b0, st_q.tidx} < DEPTH_LIM;
        tctl_wr       = bus_sel && bus_wr && (sel == RS_TCTL);
        tctl_issue    = tctl_wr && !st_q.phase && !wipe_busy;
        tctl_finish   = tctl_wr && st_q.phase;
        bus_rdy       = bus_sel && (!tctl_wr || st_q.phase);
        wr_done       = bus_rdy && bus_wr;
        wipe_start    = wr_done && (sel == RS_CTRL) && bus_wdata[BIT_WIPE];
    end

    // table memory port arbitration: the wipe owns the write port
    always_comb begin
        if (wipe_busy) begin
            ram_we    = 1'b1;
            ram_waddr = wipe_idx;
            ram_wdata = '0;
        end else begin
            ram_we    = tctl_issue && bus_wdata[BIT_STORE] && req_in_range;
            ram_waddr = req_idx[AW-1:0];
            ram_wdata = {st_q.dw[0], st_q.dw[1], st_q.dw[2]};
        end
        ram_raddr = req_idx[AW-1:0];
    end

    // next state
    always_comb begin
        st_d     = st_q;
        st_d.age = 1'b0;

        if (tctl_issue) begin
            st_d.tidx   = req_idx;
            st_d.tstore = bus_wdata[BIT_STORE];
            st_d.phase  = 1'b1;
        end

        if (tctl_finish) begin
            st_d.phase = 1'b0;
            if (!st_q.tstore) begin
                if (held_in_range) begin
                    st_d.dw[0] = ram_rdata[95:64];
                    st_d.dw[1] = ram_rdata[63:32];
                    st_d.dw[2] = ram_rdata[31:0];
                end else begin
                    st_d.dw = '0;
                end
            end
        end

        if (wr_done) begin
            unique case (sel)
                RS_CTRL: begin
                    st_d.enable = bus_wdata[BIT_ENABLE];
                    st_d.flags  = bus_wdata[FLAG_W-1:0];
                    st_d.age    = bus_wdata[BIT_AGE];
                end
                RS_PRESC: st_d.presc = bus_wdata[PRESCALE_W-1:0];
                RS_UNKV:  st_d.unkv  = bus_wdata & UNKV_KEEP;
                RS_DW:    st_d.dw[dw_idx] = bus_wdata;
                RS_PORT:  st_d.port[port_idx] = bus_wdata & PORT_KEEP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read-back path
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            RS_ID:    rd_mux = {16'h0, REV_MAJOR, REV_MINOR};
            RS_CTRL:  rd_mux = {st_q.enable, wipe_busy, 1'b0, 20'h0, st_q.flags};
            RS_PRESC: rd_mux = 32'(st_q.presc);
            RS_UNKV:  rd_mux = st_q.unkv;
            RS_TCTL:  rd_mux = 32'(st_q.tidx);
            RS_DW:    rd_mux = st_q.dw[dw_idx];
            RS_PORT:  rd_mux = st_q.port[port_idx];
            default:  rd_mux = '0;
        endcase
        bus_rdata = (bus_sel && !bus_wr) ? rd_mux : 32'h0;
    end

    assign ctrl_enable = st_q.enable;
    assign ctrl_flags  = st_q.flags;
    assign age_req     = st_q.age;
    assign clr_busy    = wipe_busy;

endmodule

// File: rtl/ltp_checker.sv
module ltp_checker
    import ltp_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic       age_bit,
    input logic       bus_rdy,
    input logic       age_req,
    input logic       clr_busy
);

    localparam int unsigned CW = $clog2(DEPTH) + 2;

    logic [CW-1:0] sweep_cnt;
    logic          tctl_wr;
    logic          ctrl_wr;

    assign tctl_wr = bus_sel && bus_wr && (bus_addr == OFS_TCTL);
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_cnt <= '0;
        end else if (clr_busy) begin
            sweep_cnt <= sweep_cnt + 1'b1;
        end else begin
            sweep_cnt <= '0;
        end
    end

    assert_tctl_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tctl_wr && bus_rdy) |-> $past(tctl_wr));

    assert_wipe_holds_tctl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && tctl_wr) |-> !bus_rdy);

    assert_age_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        age_req |=> !age_req);

    assert_age_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_rdy && age_bit) |=> age_req);

    assert_sweep_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_busy) |-> (sweep_cnt == CW'(DEPTH)));

endmodule

bind ltp_indirect_port ltp_checker #(.DEPTH(DEPTH)) i_ltp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .age_bit  (bus_wdata[29]),
    .bus_rdy  (bus_rdy),
    .age_req  (age_req),
    .clr_busy (clr_busy)
);

// File: tb/test_ltp_indirect_port.sv
module test_ltp_indirect_port;

    localparam int DEPTH = 64;
    localparam int NPORT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_rdy;
    logic        ctrl_enable;
    logic [8:0]  ctrl_flags;
    logic        age_req;
    logic        clr_busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ltp_indirect_port i_ltp_indirect_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rdy     (bus_rdy),
        .ctrl_enable (ctrl_enable),
        .ctrl_flags  (ctrl_flags),
        .age_req     (age_req),
        .clr_busy    (clr_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one transfer; returns read data and the number of cycles bus_rdy was low
    task automatic xfer(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
        waits = 0;
        rd = 32'h0;
        bus_sel = 1'b1;
        bus_wr = wr;
        bus_addr = addr;
        bus_wdata = wd;
        #1;
        while (!bus_rdy) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] rd;
        int w;
        xfer(1'b1, addr, wd, rd, w);
    endtask

    task automatic rd32(input logic [7:0] addr, output logic [31:0] rd);
        int w;
        xfer(1'b0, addr, 32'h0, rd, w);
    endtask

    function automatic logic [31:0] pat(input int i, input int w);
        return {8'(w + 1), 8'(i), 8'(~i), 8'(i * 3 + w)};
    endfunction

    task automatic fetch_check(input int idx, input logic [31:0] e0, input logic [31:0] e1,
                               input logic [31:0] e2, input string req);
        logic [31:0] rd;
        int w;
        xfer(1'b1, 8'h20, 32'(idx), rd, w);
        rd32(8'h34, rd); chk(req, rd, e0);
        rd32(8'h38, rd); chk(req, rd, e1);
        rd32(8'h3C, rd); chk(req, rd, e2);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 enable", 32'(ctrl_enable), 0);
        chk("R1 flags", 32'(ctrl_flags), 0);
        chk("R1 age_req", 32'(age_req), 0);
        chk("R1 clr_busy", 32'(clr_busy), 0);
        rd32(8'h08, rd); chk("R1 ctrl", rd, 0);
        rd32(8'h20, rd); chk("R1 tctl", rd, 0);

        // R2 revision register, read only
        rd32(8'h00, rd); chk("R2 id", rd, 32'h0000_0103);
        wr32(8'h00, 32'hFFFF_FFFF);
        rd32(8'h00, rd); chk("R2 id after write", rd, 32'h0000_0103);

        // R3 control bits
        wr32(8'h08, 32'h8000_01A5);
        rd32(8'h08, rd); chk("R3 ctrl readback", rd, 32'h8000_01A5);
        chk("R3 enable out", 32'(ctrl_enable), 1);
        chk("R3 flags out", 32'(ctrl_flags), 32'h1A5);
        wr32(8'h08, 32'h1FFF_FE00);
        rd32(8'h08, rd); chk("R3 ignored bits", rd, 0);
        chk("R3 enable cleared", 32'(ctrl_enable), 0);

        // R4 ageing pulse
        wr32(8'h08, 32'hA000_0000);
        chk("R4 pulse high", 32'(age_req), 1);
        @(negedge clk);
        chk("R4 pulse low", 32'(age_req), 0);
        rd32(8'h08, rd); chk("R4 bit29 reads 0", rd, 32'h8000_0000);

        // R5 wipe length
        wr32(8'h08, 32'hC000_0000);
        n = 0;
        while (clr_busy) begin
            n++;
            @(negedge clk);
        end
        chk("R5 wipe cycles", 32'(n), 32'(DEPTH));

        // R6 R7 R8 exhaustive store and fetch
        for (int i = 0; i < DEPTH; i++) begin
            wr32(8'h34, pat(i, 0));
            wr32(8'h38, pat(i, 1));
            wr32(8'h3C, pat(i, 2));
            xfer(1'b1, 8'h20, 32'h8000_0000 | 32'(i), rd, w);
            if (i == 0 || i == DEPTH - 1) chk("R8 store stall", 32'(w), 1);
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            xfer(1'b1, 8'h20, 32'(i), rd, w);
            if (i == 7) chk("R8 fetch stall", 32'(w), 1);
            rd32(8'h20, rd); chk("R12 tctl index", rd, 32'(i));
            rd32(8'h34, rd); chk("R7 word0", rd, pat(i, 0));
            rd32(8'h38, rd); chk("R7 word1", rd, pat(i, 1));
            rd32(8'h3C, rd); chk("R6 word2", rd, pat(i, 2));
        end

        // R9 out of range index
        wr32(8'h34, 32'hDEAD_0001);
        wr32(8'h38, 32'hDEAD_0002);
        wr32(8'h3C, 32'hDEAD_0003);
        wr32(8'h20, 32'h8000_0000 | 32'(DEPTH));
        fetch_check(0, pat(0, 0), pat(0, 1), pat(0, 2), "R9 store ignored");
        fetch_check(DEPTH, 0, 0, 0, "R9 fetch zero");
        fetch_check(1023, 0, 0, 0, "R9 fetch zero top");

        // R5 wipe clears, bit30 visible while busy
        wr32(8'h08, 32'h4000_0000);
        rd32(8'h08, rd); chk("R5 bit30 busy", rd, 32'h4000_0000);
        while (clr_busy) @(negedge clk);
        rd32(8'h08, rd); chk("R5 bit30 done", rd, 0);
        for (int i = 0; i < DEPTH; i += 9)
            fetch_check(i, 0, 0, 0, "R5 entry zero");

        // R10 store issued at start of a wipe
        wr32(8'h34, 32'h1111_1111);
        wr32(8'h38, 32'h2222_2222);
        wr32(8'h3C, 32'h3333_3333);
        wr32(8'h08, 32'h4000_0000);
        xfer(1'b1, 8'h20, 32'h8000_0005, rd, w);
        chk("R10 stall cycles", 32'(w), 32'(DEPTH + 1));
        fetch_check(5, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, "R10 store lands");

        // R11 other registers
        wr32(8'h10, 32'hFFFF_FFFF);
        rd32(8'h10, rd); chk("R11 prescale", rd, 32'h000F_FFFF);
        wr32(8'h18, 32'hFFFF_FFFF);
        rd32(8'h18, rd); chk("R11 unknown vlan", rd, 32'h3F3F_3F3F);
        for (int p = 0; p < NPORT; p++)
            wr32(8'(8'h40 + 4 * p), 32'hA5A5_A5A5 ^ 32'(p * 32'h0101_0101));
        wr32(8'h4C, 32'hFFFF_FFFF);
        wr32(8'h41, 32'hFFFF_FFFF);
        for (int p = 0; p < NPORT; p++) begin
            rd32(8'(8'h40 + 4 * p), rd);
            chk("R11 port word", rd, (32'hA5A5_A5A5 ^ 32'(p * 32'h0101_0101)) & 32'hFFFF_003F);
        end
        rd32(8'h4C, rd); chk("R11 port beyond", rd, 0);
        rd32(8'h41, rd); chk("R11 misaligned", rd, 0);
        rd32(8'h24, rd); chk("R11 unmapped", rd, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule